// File: doc/BRIEF.md
# Interleaved Dual-Bridge Unipolar PWM Modulator

This block drives two single-phase full bridges that draw from one DC bus. Both bridges follow the same sine reference, with the same amplitude and phase, and each bridge applies three-level (unipolar) sine-triangle modulation. Leg A compares the reference with the carrier. Leg B compares the negated reference with the same carrier. This places each bridge's dominant DC-side ripple at twice the carrier frequency.

The second bridge's carrier is the first bridge's carrier advanced by a programmable count. With a quarter-period advance, the ripple currents of the two bridges interleave on the bus and partly cancel. With a zero advance, the bridges switch in lockstep, which is conventional operation. The fundamental output voltage of each bridge does not depend on the advance.

Both triangles come from one counter, so they stay locked to each other. The carrier period is a parameter: at a 100 MHz clock, `HALF = 2500` gives a 20 kHz carrier and `HALF = 10000` gives the scaled-down 5 kHz carrier. The bench uses a small configuration of the same parameters.

Top module: `twin_bridge_pwm`

## Requirements
- R1: The carrier counter steps through 0 to 2·HALF−1 and then wraps, once per clock while enabled, so the carrier period is 2·HALF clocks. For a count t, the triangle height is t when t ≤ HALF and 2·HALF−t otherwise. The bipolar carrier is 2·height − HALF. Bridge 1 uses count t directly, so its carrier has zero phase.
- R2: Bridge 2 uses the count (t + shift) mod 2·HALF. When shift is 0, gate_b equals gate_a on every cycle. When shift is HALF/2 and the reference is zero, gate_b leads gate_a by HALF/2 clocks.
- R3: A phase accumulator of ACC_W bits starts at 0 and adds the latched step at every counter wrap. Its top log2(LUT_DEPTH) bits give a table index k. With Hh = LUT_DEPTH/2 and x = k mod Hh, the table value is s = ⌊HALF·16x(Hh−x) / (5Hh² − 4x(Hh−x))⌋, negated when k ≥ Hh. The reference is ⌊s·mi / 2^MI_W⌋, rounded toward minus infinity. One reference serves both bridges.
- R4: For each bridge, the ideal state of leg A is "reference > carrier" and the ideal state of leg B is "−reference > carrier". The ideal states are taken from the registered counter, accumulator and latched settings.
- R5: Each leg registers its ideal state and counts how many consecutive cycles that state has held, saturating at 2^DT_W−1. The high switch is on when the registered state is 1 and the run count is at least dead_cyc. The low switch is on when the registered state is 0, the block is enabled, and the run count is at least dead_cyc. Gate bit order per bridge is {B low, B high, A low, A high}.
- R6: The high and low switches of a leg are never on in the same cycle.
- R7: The modulation index, shift and step are taken from the inputs only at a counter wrap, or on any cycle while disabled. Changes at other times do not affect the outputs until the next wrap.
- R8: One clock after en is sampled low, all eight gates are low. While disabled, the counter and accumulator are held at 0 and each leg's registered state and run count are cleared. On re-enable, the carriers restart from count 0 using the latched shift.
- R9: During reset, all gates are low and every register, including the latched settings, is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low forces all gates off |
| mod_idx | input | MI_W | Modulation index, fraction of 2^MI_W |
| car_shift | input | log2(2·HALF) | Bridge 2 carrier advance in counts |
| sin_step | input | ACC_W | Accumulator step per carrier period |
| dead_cyc | input | DT_W | Dead time in clock cycles |
| gate_a | output | 4 | Bridge 1 gates {B lo, B hi, A lo, A hi} |
| gate_b | output | 4 | Bridge 2 gates {B lo, B hi, A lo, A hi} |

## Verification
The assertions take for granted that car_shift stays below 2·HALF. They also take for granted that dead_cyc is held steady around each high-switch turn-on whenever the dead-time gap is checked. The zero-shift property holds only while car_shift has stayed at zero since the block was last disabled. The stimulus sweeps every legal shift of a 16-count period, which lies entirely within the legal range. It changes dead_cyc only while the bridges are disabled and changes the other settings at points inside a carrier period, so that the latching at the wrap is exercised.

// File: rtl/twin_bridge_pwm.sv
module twin_bridge_pwm #(
  parameter int HALF      = 2500,
  parameter int LUT_DEPTH = 64,
  parameter int ACC_W     = 16,
  parameter int MI_W      = 8,
  parameter int DT_W      = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic [MI_W-1:0]               mod_idx,
  input  logic [$clog2(2*HALF)-1:0]     car_shift,
  input  logic [ACC_W-1:0]              sin_step,
  input  logic [DT_W-1:0]               dead_cyc,
  output logic [3:0]                    gate_a,
  output logic [3:0]                    gate_b
);
  localparam int PER = 2 * HALF;
  localparam int CW  = $clog2(PER);
  localparam int RW  = CW + 2;
  localparam int LW  = $clog2(LUT_DEPTH);
  localparam int HH  = LUT_DEPTH / 2;

  function automatic int sine_pt(input int k);
    longint x, num, den, v;
    x   = k % HH;
    num = 16 * x * (HH - x);
    den = 5 * HH * HH - 4 * x * (HH - x);
    v   = (HALF * num) / den;
    return (k >= HH) ? int'(-v) : int'(v);
  endfunction

  function automatic logic signed [RW-1:0] bip(input logic [CW-1:0] t);
    logic [CW:0] ht;
    ht = (t <= CW'(HALF)) ? {1'b0, t} : (CW+1)'(PER) - {1'b0, t};
    return $signed({1'b0, ht, 1'b0}) - RW'(HALF);
  endfunction

  logic signed [RW-1:0] lut [LUT_DEPTH];
  for (genvar k = 0; k < LUT_DEPTH; k++) begin : g_lut
    assign lut[k] = RW'(sine_pt(k));
  end

  logic [CW-1:0]   cnt, sh_q, c2;
  logic [ACC_W-1:0] ph, st_q;
  logic [MI_W-1:0] mi_q;
  logic            en_q;
  logic [CW:0]     c2s;
  wire             wrap = (cnt == CW'(PER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; ph <= '0; mi_q <= '0; sh_q <= '0; st_q <= '0; en_q <= 1'b0;
    end else if (!en) begin
      cnt <= '0; ph <= '0; en_q <= 1'b0;
      mi_q <= mod_idx; sh_q <= car_shift; st_q <= sin_step;
    end else begin
      en_q <= 1'b1;
      cnt  <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        ph   <= ph + st_q;
        mi_q <= mod_idx; sh_q <= car_shift; st_q <= sin_step;
      end
    end
  end

  assign c2s = {1'b0, cnt} + {1'b0, sh_q};
  assign c2  = (c2s >= (CW+1)'(PER)) ? CW'(c2s - (CW+1)'(PER)) : CW'(c2s);

  logic signed [RW+MI_W:0] prod;
  logic signed [RW-1:0]    ref_v, nref, car1, car2;
  assign prod  = lut[ph[ACC_W-1 -: LW]] * $signed({1'b0, mi_q});
  assign ref_v = prod[MI_W +: RW];
  assign nref  = -ref_v;
  assign car1  = bip(cnt);
  assign car2  = bip(c2);

  logic [3:0] ideal, hi, lo;
  assign ideal = {nref > car2, ref_v > car2, nref > car1, ref_v > car1};

  for (genvar i = 0; i < 4; i++) begin : g_leg
    logic            s_q;
    logic [DT_W-1:0] run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || !en) begin
        s_q <= 1'b0; run <= '0;
      end else begin
        s_q <= ideal[i];
        if (ideal[i] != s_q) run <= '0;
        else if (run != '1)  run <= run + 1'b1;
      end
    end
    assign hi[i] = s_q && (run >= dead_cyc);
    assign lo[i] = en_q && !s_q && (run >= dead_cyc);
  end

  assign gate_a = {lo[1], hi[1], lo[0], hi[0]};
  assign gate_b = {lo[3], hi[3], lo[2], hi[2]};
endmodule

// File: rtl/twin_bridge_pwm_chk.sv
module twin_bridge_pwm_chk #(
  parameter int HALF = 2500,
  parameter int DT_W = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      en,
  input logic [$clog2(2*HALF)-1:0] car_shift,
  input logic [DT_W-1:0]           dead_cyc,
  input logic [3:0]                gate_a,
  input logic [3:0]                gate_b
);
  wire [7:0] g = {gate_b, gate_a};
  logic zero_since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              zero_since <= 1'b1;
    else if (!en)            zero_since <= (car_shift == '0);
    else if (car_shift != 0) zero_since <= 1'b0;
  end

  for (genvar i = 0; i < 4; i++) begin : g_leg
    p_leg_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(g[2*i] && g[2*i+1]));
    p_dead_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dead_cyc != '0 && $stable(dead_cyc) && $rose(g[2*i])) |-> !$past(g[2*i+1]));
  end

  p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (g == 8'h00));

  p_zero_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    zero_since |-> (gate_a == gate_b));
endmodule

bind twin_bridge_pwm twin_bridge_pwm_chk #(.HALF(HALF), .DT_W(DT_W)) u_chk (.*);

// File: tb/twin_bridge_pwm_test.sv
`timescale 1ns/1ps
module twin_bridge_pwm_test;
  localparam int HALF = 8, LUT_DEPTH = 16, ACC_W = 8, MI_W = 4, DT_W = 3;
  localparam int PER = 2 * HALF, LW = 4;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [MI_W-1:0]  mod_idx = '0;
  logic [3:0]       car_shift = '0;
  logic [ACC_W-1:0] sin_step = '0;
  logic [DT_W-1:0]  dead_cyc = '0;
  logic [3:0]       gate_a, gate_b;

  always #5 clk = ~clk;

  twin_bridge_pwm #(.HALF(HALF), .LUT_DEPTH(LUT_DEPTH), .ACC_W(ACC_W), .MI_W(MI_W), .DT_W(DT_W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mod_idx(mod_idx), .car_shift(car_shift),
    .sin_step(sin_step), .dead_cyc(dead_cyc), .gate_a(gate_a), .gate_b(gate_b));

  int checks = 0, fails = 0;
  string tag = "R9";
  bit same_req = 0, quarter_req = 0, period_req = 0;
  int ph_cyc = 0;
  logic [3:0] hist_a [32];
  logic [3:0] hist_b [32];

  int m_cnt, m_ph, m_mi, m_sh, m_st, m_enq;
  int m_sq [4];
  int m_run [4];

  function automatic int f_sine(input int k);
    int hh, x, num, den, v;
    hh = LUT_DEPTH / 2; x = k % hh;
    num = 16 * x * (hh - x);
    den = 5 * hh * hh - 4 * x * (hh - x);
    v = (HALF * num) / den;
    return (k >= hh) ? -v : v;
  endfunction

  function automatic int f_ref(input int p, input int m);
    int pr;
    pr = f_sine(p >> (ACC_W - LW)) * m;
    if (pr >= 0) return pr / (1 << MI_W);
    return -((-pr + (1 << MI_W) - 1) / (1 << MI_W));
  endfunction

  function automatic int f_car(input int t);
    int h;
    h = (t <= HALF) ? t : PER - t;
    return 2 * h - HALF;
  endfunction

  function automatic logic [7:0] f_exp();
    logic [7:0] e;
    bit ok;
    e = '0;
    for (int i = 0; i < 4; i++) begin
      ok = (m_run[i] >= int'(dead_cyc));
      e[2*i]   = (m_sq[i] == 1) && ok;
      e[2*i+1] = (m_enq == 1) && (m_sq[i] == 0) && ok;
    end
    return e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int r, c1, c2;
    int id [4];
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_mi = 0; m_sh = 0; m_st = 0; m_enq = 0;
      for (int i = 0; i < 4; i++) begin m_sq[i] = 0; m_run[i] = 0; end
    end else if (!en) begin
      m_cnt = 0; m_ph = 0; m_enq = 0;
      m_mi = int'(mod_idx); m_sh = int'(car_shift); m_st = int'(sin_step);
      for (int i = 0; i < 4; i++) begin m_sq[i] = 0; m_run[i] = 0; end
    end else begin
      r  = f_ref(m_ph, m_mi);
      c1 = f_car(m_cnt);
      c2 = f_car((m_cnt + m_sh) % PER);
      id[0] = int'(r > c1); id[1] = int'(-r > c1);
      id[2] = int'(r > c2); id[3] = int'(-r > c2);
      for (int i = 0; i < 4; i++) begin
        if (id[i] != m_sq[i]) m_run[i] = 0;
        else if (m_run[i] < (1 << DT_W) - 1) m_run[i] = m_run[i] + 1;
        m_sq[i] = id[i];
      end
      m_enq = 1;
      if (m_cnt == PER - 1) begin
        m_cnt = 0;
        m_ph = (m_ph + m_st) % (1 << ACC_W);
        m_mi = int'(mod_idx); m_sh = int'(car_shift); m_st = int'(sin_step);
      end else m_cnt = m_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] e;
    e = f_exp();
    check({gate_b, gate_a} == e, tag, {gate_b, gate_a}, e);
    if (same_req) check(gate_a == gate_b, "R2 zero shift", {4'h0, gate_b}, {4'h0, gate_a});
    if (quarter_req && ph_cyc >= 8)
      check(gate_a == hist_b[(ph_cyc - HALF/2) % 32], "R2 quarter lead",
            {4'h0, gate_a}, {4'h0, hist_b[(ph_cyc - HALF/2) % 32]});
    if (period_req && ph_cyc >= PER + 2)
      check(gate_a == hist_a[(ph_cyc - PER) % 32], "R1 period",
            {4'h0, gate_a}, {4'h0, hist_a[(ph_cyc - PER) % 32]});
    hist_a[ph_cyc % 32] = gate_a;
    hist_b[ph_cyc % 32] = gate_b;
    ph_cyc++;
  end

  task automatic run(input int mi, input int sh, input int st, input int dt, input int n,
                     input string tg, input bit same, input bit quarter, input bit period);
    @(posedge clk); #1;
    en = 1'b0; tag = "R8 disabled"; same_req = 0; quarter_req = 0; period_req = 0;
    repeat (3) @(posedge clk);
    #1;
    mod_idx = MI_W'(mi); car_shift = 4'(sh); sin_step = ACC_W'(st); dead_cyc = DT_W'(dt);
    @(posedge clk); #1;
    en = 1'b1; tag = tg; same_req = same; quarter_req = quarter; period_req = period; ph_cyc = 0;
    repeat (n) @(posedge clk);
  endtask

  task automatic retune(input int mi, input int sh, input int st, input int n);
    @(posedge clk); #1;
    mod_idx = MI_W'(mi); car_shift = 4'(sh); sin_step = ACC_W'(st);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tag = "R9 reset";
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1; tag = "R8 idle";
    repeat (4) @(posedge clk);
    run(0, 0, 0, 0, 80, "R1 carrier", 1, 0, 1);
    run(0, HALF/2, 0, 0, 80, "R2 quarter", 0, 1, 0);
    run(13, HALF/2, 5, 0, 2000, "R3 R4 reference", 0, 0, 0);
    for (int d = 0; d < 8; d++) run(13, HALF/2, 37, d, 200, "R5 R6 dead time", 0, 0, 0);
    for (int s = 0; s < 16; s++) run(15, s, 11, 2, 100, "R2 shift sweep", s == 0, 0, 0);
    run(12, 4, 9, 1, 21, "R7 latch", 0, 0, 0);
    retune(3, 7, 40, 23);
    retune(15, 0, 2, 37);
    retune(8, 12, 90, 45);
    retune(13, 4, 7, 60);
    for (int m = 0; m < 16; m++) run(m, HALF/2, 19, 1, 150, "R3 index sweep", 0, 0, 0);
    run(13, 4, 5, 3, 30, "R8 re-enable", 0, 0, 0);
    @(posedge clk); #1 en = 1'b0; tag = "R8 disabled";
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b0; tag = "R9 reset";
    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule